// File: doc/BRIEF.md
# External SRAM March Self-Test with Scan-Port Control

This block sits in a board FPGA and tests an external asynchronous static RAM with a 4-bit word at functional speed, with no processor involved. A small JTAG test access port inside the block takes the commands. One instruction launches the test. A second instruction exposes a result register that holds busy, done and fail flags plus a record of the first miscompare. Every other instruction code selects a one-bit bypass path, so the block can sit alone on the scan bus or be one device in a longer chain.

The engine runs a six-element March C- pass over every address. It drives the address, the write data and its enable, and the active-low chip-enable, write-enable and output-enable pins. It compares each read word with the value the algorithm expects. The scan port is sampled in the system clock domain, so the scan clock must run several times slower than the system clock. The address width defaults to 18 bits, for 256K words.

Top module: `sram_march_bist`

## Requirements
- R1: Loading instruction code 4'h5 into the 4-bit instruction register and then entering Run-Test/Idle starts the test, and busy reads 1 while it runs.
- R2: The pass runs six elements in this order: ascending write 0; ascending read 0 then write 1; ascending read 1 then write 0; descending read 0 then write 1; descending read 1 then write 0; descending read 0. The value 0 is the all-zero word and 1 is the all-ones word. A full pass therefore makes 5N write windows and 5N read windows, and it leaves every word at zero.
- R3: A write holds chip-enable and write-enable low for exactly two system clocks with output-enable high, and data is driven only in that window. A read holds chip-enable and output-enable low for exactly two clocks and samples on the second. The address is stable while chip-enable is low.
- R4: Instruction code 4'h6 selects a result register, shifted out LSB first. Its fields, from MSB down, are {busy, done, fail, element[2:0], address[A-1:0], expected[3:0], actual[3:0]}. On a fault-free memory the pass ends with busy=0, done=1 and fail=0.
- R5: At the first miscompare the engine records the element index, the address, the expected word and the read word, and it sets a sticky fail flag. Later miscompares leave the record unchanged, and the pass runs to completion.
- R6: A start request that arrives while the test is busy is ignored, and the running pass is not restarted.
- R7: Entering Test-Logic-Reset aborts the test. All memory controls go inactive, the data bus is released, no further accesses occur, and the result register reads all zero.
- R8: Every instruction other than the start and result codes, including the all-ones reset value, selects a one-bit bypass register that captures 0. Capture-IR loads 4'b0001.
- R9: After reset every memory control is inactive, the data bus is released and the scan output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the memory test runs at this rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tck | input | 1 | Scan clock, sampled by clk |
| tms | input | 1 | Scan mode select |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out, updated after the falling scan-clock edge |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Write data |
| mem_dout_en | output | 1 | Drive enable for the bidirectional data pins |
| mem_din | input | DATA_W | Data read from the pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that the scan clock is held at least three system clocks in each phase, so every scan edge is seen once through the synchronizer. They also assume that tms and tdi are steady around each rising scan-clock edge. The bench toggles the scan clock every four system clocks and changes tms and tdi only while the scan clock is low. It supplies read data from a combinational memory model that answers only while chip-enable and output-enable are both low. Stuck bits are injected in that model's read path, which gives known miscompares.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

  typedef enum logic [3:0] {
    T_RESET, T_IDLE,
    T_SEL_DR, T_CAP_DR, T_SHF_DR, T_EX1_DR, T_PAU_DR, T_EX2_DR, T_UPD_DR,
    T_SEL_IR, T_CAP_IR, T_SHF_IR, T_EX1_IR, T_PAU_IR, T_EX2_IR, T_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_ACT1, E_ACT2} eng_st_e;

  localparam logic [2:0] LAST_ELEM = 3'd5;

  function automatic tap_st_e tap_step(tap_st_e s, logic m);
    case (s)
      T_RESET:  return m ? T_RESET  : T_IDLE;
      T_IDLE:   return m ? T_SEL_DR : T_IDLE;
      T_SEL_DR: return m ? T_SEL_IR : T_CAP_DR;
      T_CAP_DR: return m ? T_EX1_DR : T_SHF_DR;
      T_SHF_DR: return m ? T_EX1_DR : T_SHF_DR;
      T_EX1_DR: return m ? T_UPD_DR : T_PAU_DR;
      T_PAU_DR: return m ? T_EX2_DR : T_PAU_DR;
      T_EX2_DR: return m ? T_UPD_DR : T_SHF_DR;
      T_UPD_DR: return m ? T_SEL_DR : T_IDLE;
      T_SEL_IR: return m ? T_RESET  : T_CAP_IR;
      T_CAP_IR: return m ? T_EX1_IR : T_SHF_IR;
      T_SHF_IR: return m ? T_EX1_IR : T_SHF_IR;
      T_EX1_IR: return m ? T_UPD_IR : T_PAU_IR;
      T_PAU_IR: return m ? T_EX2_IR : T_PAU_IR;
      T_EX2_IR: return m ? T_UPD_IR : T_SHF_IR;
      T_UPD_IR: return m ? T_SEL_DR : T_IDLE;
      default:  return T_RESET;
    endcase
  endfunction

  // march element properties
  function automatic logic elem_down(logic [2:0] e);
    return e >= 3'd3;
  endfunction

  function automatic logic elem_two_ops(logic [2:0] e);
    return (e != 3'd0) && (e != LAST_ELEM);
  endfunction

  function automatic logic op_reads(logic [2:0] e, logic opi);
    return (e == LAST_ELEM) || ((e != 3'd0) && !opi);
  endfunction

  function automatic logic op_ones(logic [2:0] e, logic opi);
    if (op_reads(e, opi)) return (e == 3'd2) || (e == 3'd4);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

endpackage

// File: rtl/sbist_tap.sv
module sbist_tap
  import sbist_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int ST_W = 32,
  parameter logic [IR_W-1:0] RUN_CODE = 'h5,
  parameter logic [IR_W-1:0] RES_CODE = 'h6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  input  logic [ST_W-1:0] status_i,
  output logic            start_o,
  output logic            abort_o
);

  logic [2:0]      tck_q;
  logic [1:0]      tms_q, tdi_q;
  tap_st_e         st_q, st_nx;
  logic [IR_W-1:0] ir_q, ir_nx, irsr_q, irsr_nx;
  logic [ST_W-1:0] dr_q, dr_nx;
  logic            byp_q, byp_nx, tdo_q, tdo_nx, start_q, start_nx;
  logic            rise, fall, sel_res;

  always_comb begin
    rise     = tck_q[1] & ~tck_q[2];
    fall     = ~tck_q[1] & tck_q[2];
    sel_res  = (ir_q == RES_CODE);
    st_nx    = rise ? tap_step(st_q, tms_q[1]) : st_q;
    ir_nx    = ir_q;
    irsr_nx  = irsr_q;
    dr_nx    = dr_q;
    byp_nx   = byp_q;
    tdo_nx   = tdo_q;
    start_nx = rise && (st_nx == T_IDLE) && (st_q != T_IDLE) && (ir_q == RUN_CODE);
    if (rise) begin
      case (st_q)
        T_CAP_IR: irsr_nx = {{(IR_W-2){1'b0}}, 2'b01};
        T_SHF_IR: irsr_nx = {tdi_q[1], irsr_q[IR_W-1:1]};
        T_CAP_DR: if (sel_res) dr_nx = status_i; else byp_nx = 1'b0;
        T_SHF_DR: if (sel_res) dr_nx = {tdi_q[1], dr_q[ST_W-1:1]}; else byp_nx = tdi_q[1];
        default: ;
      endcase
    end
    if (fall) begin
      if (st_q == T_UPD_IR) ir_nx = irsr_q;
      if (st_q == T_SHF_DR)      tdo_nx = sel_res ? dr_q[0] : byp_q;
      else if (st_q == T_SHF_IR) tdo_nx = irsr_q[0];
      else                       tdo_nx = 1'b0;
    end
    if (st_q == T_RESET) ir_nx = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q   <= '0;
      tms_q   <= '0;
      tdi_q   <= '0;
      st_q    <= T_RESET;
      ir_q    <= '1;
      irsr_q  <= '0;
      dr_q    <= '0;
      byp_q   <= 1'b0;
      tdo_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      tck_q   <= {tck_q[1:0], tck};
      tms_q   <= {tms_q[0], tms};
      tdi_q   <= {tdi_q[0], tdi};
      st_q    <= st_nx;
      ir_q    <= ir_nx;
      irsr_q  <= irsr_nx;
      dr_q    <= dr_nx;
      byp_q   <= byp_nx;
      tdo_q   <= tdo_nx;
      start_q <= start_nx;
    end
  end

  assign tdo     = tdo_q;
  assign start_o = start_q;
  assign abort_o = (st_q == T_RESET);

endmodule

// File: rtl/sbist_march.sv
module sbist_march
  import sbist_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4,
  localparam int ST_W  = 6 + ADDR_W + 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ST_W-1:0]   status_o,
  output logic              busy_o
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  eng_st_e           st_q, st_nx;
  logic [2:0]        elem_q, elem_nx, f_elem_q, f_elem_nx;
  logic              opi_q, opi_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx, f_addr_q, f_addr_nx, end_addr;
  logic [DATA_W-1:0] f_exp_q, f_exp_nx, f_act_q, f_act_nx, exp_val;
  logic [DATA_W-1:0] dout_q, dout_nx;
  logic              busy_q, busy_nx, done_q, done_nx, fail_q, fail_nx;
  logic              ce_q, ce_nx, we_q, we_nx, oe_q, oe_nx, den_q, den_nx;
  logic              rd, ones, down, mism, act_nx;

  always_comb begin
    rd        = op_reads(elem_q, opi_q);
    ones      = op_ones(elem_q, opi_q);
    down      = elem_down(elem_q);
    exp_val   = ones ? '1 : '0;
    end_addr  = down ? '0 : ADDR_MAX;
    mism      = (mem_din != exp_val);
    st_nx     = st_q;
    elem_nx   = elem_q;
    opi_nx    = opi_q;
    addr_nx   = addr_q;
    busy_nx   = busy_q;
    done_nx   = done_q;
    fail_nx   = fail_q;
    f_elem_nx = f_elem_q;
    f_addr_nx = f_addr_q;
    f_exp_nx  = f_exp_q;
    f_act_nx  = f_act_q;
    case (st_q)
      E_IDLE: begin
        if (start_i) begin
          busy_nx   = 1'b1;
          done_nx   = 1'b0;
          fail_nx   = 1'b0;
          f_elem_nx = '0;
          f_addr_nx = '0;
          f_exp_nx  = '0;
          f_act_nx  = '0;
          elem_nx   = '0;
          opi_nx    = 1'b0;
          addr_nx   = '0;
          st_nx     = E_SETUP;
        end
      end
      E_SETUP: st_nx = E_ACT1;
      E_ACT1:  st_nx = E_ACT2;
      E_ACT2: begin
        if (rd && mism) begin
          fail_nx = 1'b1;
          if (!fail_q) begin
            f_elem_nx = elem_q;
            f_addr_nx = addr_q;
            f_exp_nx  = exp_val;
            f_act_nx  = mem_din;
          end
        end
        st_nx = E_SETUP;
        if (elem_two_ops(elem_q) && !opi_q) begin
          opi_nx = 1'b1;
        end else begin
          opi_nx = 1'b0;
          if (addr_q != end_addr) begin
            addr_nx = down ? addr_q - 1'b1 : addr_q + 1'b1;
          end else if (elem_q == LAST_ELEM) begin
            st_nx   = E_IDLE;
            busy_nx = 1'b0;
            done_nx = 1'b1;
          end else begin
            elem_nx = elem_q + 3'd1;
            addr_nx = elem_down(elem_q + 3'd1) ? ADDR_MAX : '0;
          end
        end
      end
      default: st_nx = E_IDLE;
    endcase
    if (abort_i) begin
      st_nx     = E_IDLE;
      busy_nx   = 1'b0;
      done_nx   = 1'b0;
      fail_nx   = 1'b0;
      f_elem_nx = '0;
      f_addr_nx = '0;
      f_exp_nx  = '0;
      f_act_nx  = '0;
    end
    act_nx  = (st_nx == E_ACT1) || (st_nx == E_ACT2);
    ce_nx   = ~act_nx;
    we_nx   = ~(act_nx & ~rd);
    oe_nx   = ~(act_nx & rd);
    den_nx  = act_nx & ~rd;
    dout_nx = ones ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= E_IDLE;
      elem_q   <= '0;
      opi_q    <= 1'b0;
      addr_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      f_elem_q <= '0;
      f_addr_q <= '0;
      f_exp_q  <= '0;
      f_act_q  <= '0;
      ce_q     <= 1'b1;
      we_q     <= 1'b1;
      oe_q     <= 1'b1;
      den_q    <= 1'b0;
      dout_q   <= '0;
    end else begin
      st_q     <= st_nx;
      elem_q   <= elem_nx;
      opi_q    <= opi_nx;
      addr_q   <= addr_nx;
      busy_q   <= busy_nx;
      done_q   <= done_nx;
      fail_q   <= fail_nx;
      f_elem_q <= f_elem_nx;
      f_addr_q <= f_addr_nx;
      f_exp_q  <= f_exp_nx;
      f_act_q  <= f_act_nx;
      ce_q     <= ce_nx;
      we_q     <= we_nx;
      oe_q     <= oe_nx;
      den_q    <= den_nx;
      dout_q   <= dout_nx;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_dout    = dout_q;
  assign mem_dout_en = den_q;
  assign mem_ce_n    = ce_q;
  assign mem_we_n    = we_q;
  assign mem_oe_n    = oe_q;
  assign busy_o      = busy_q;
  assign status_o    = {busy_q, done_q, fail_q, f_elem_q, f_addr_q, f_exp_q, f_act_q};

endmodule

// File: rtl/sram_march_bist.sv
module sram_march_bist #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4,
  parameter int IR_W   = 4,
  parameter logic [IR_W-1:0] RUN_CODE = 'h5,
  parameter logic [IR_W-1:0] RES_CODE = 'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int ST_W = 6 + ADDR_W + 2 * DATA_W;

  logic [1:0]      rst_sync;
  logic            rst_n_s;
  logic [ST_W-1:0] status;
  logic            tap_start, tap_abort, eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  sbist_tap #(
    .IR_W(IR_W), .ST_W(ST_W), .RUN_CODE(RUN_CODE), .RES_CODE(RES_CODE)
  ) u_tap (
    .clk(clk), .rst_n(rst_n_s), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .status_i(status), .start_o(tap_start), .abort_o(tap_abort)
  );

  sbist_march #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .start_i(tap_start), .abort_i(tap_abort),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .status_o(status), .busy_o(eng_busy)
  );

endmodule

// File: rtl/sram_march_bist_chk.sv
module sram_march_bist_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dout_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              abort
);

  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  p_drive_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!we_n && !ce_n && oe_n));

  p_we_has_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !ce_n);

  p_we_min_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |=> !we_n);

  p_we_max_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !$past(we_n)) |=> we_n);

  p_oe_min_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |=> !oe_n);

  p_oe_max_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !$past(oe_n)) |=> oe_n);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> $stable(addr));

  p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n && we_n && oe_n && !dout_en));

  p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

bind sram_march_bist sram_march_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ce_n(mem_ce_n), .we_n(mem_we_n),
  .oe_n(mem_oe_n), .dout_en(mem_dout_en), .addr(mem_addr),
  .busy(eng_busy), .abort(tap_abort)
);

// File: tb/sim_sram_march_bist.sv
`timescale 1ns/1ps
module sim_sram_march_bist;

  localparam int AW = 5;
  localparam int NW = 1 << AW;
  localparam int SW = 6 + AW + 8;

  logic clk, rst_n, tck, tms, tdi, tdo;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_dout, mem_din;
  logic mem_dout_en, mem_ce_n, mem_we_n, mem_oe_n;

  int checks = 0, failures = 0;
  int mon_wr = 0, mon_rd = 0, mon_viol = 0, we_len = 0, oe_len = 0;
  logic [3:0] sram [NW];
  logic fill_req, sa1_on, sa0_on;
  logic [AW-1:0] sa1_a, sa0_a;

  sram_march_bist #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: combinational read, stuck bits in the read path
  always_comb begin
    logic [3:0] v;
    v = sram[mem_addr];
    if (sa1_on && mem_addr == sa1_a) v[0] = 1'b1;
    if (sa0_on && mem_addr == sa0_a) v[3] = 1'b0;
    mem_din = (!mem_ce_n && !mem_oe_n) ? v : 4'hA;
  end

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < NW; i++) sram[i] <= 4'h5;
    end else if (!mem_ce_n && !mem_we_n && mem_dout_en) begin
      sram[mem_addr] <= mem_dout;
    end
  end

  // pin-timing monitor (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) we_len++;
      else if (we_len != 0) begin
        if (we_len != 2) mon_viol++;
        mon_wr++;
        we_len = 0;
      end
      if (!mem_oe_n) oe_len++;
      else if (oe_len != 0) begin
        if (oe_len != 2) mon_viol++;
        mon_rd++;
        oe_len = 0;
      end
      if ((!mem_we_n && !mem_oe_n) || (mem_dout_en != !mem_we_n) ||
          ((!mem_we_n || !mem_oe_n) && mem_ce_n)) mon_viol++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tck_cyc(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    repeat (4) @(negedge clk);
    o = tdo;
    tck = 1'b1;
    repeat (4) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      tck_cyc(i == 3, code[i], o);
      cap[i] = o;
    end
    tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tck_cyc(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tck_cyc(1'b1, 1'b0, o);
    tck_cyc(1'b0, 1'b0, o);
  endtask

  task automatic read_status(output logic [SW-1:0] s);
    logic [3:0] cap;
    logic [31:0] d;
    shift_ir(4'h6, cap);
    shift_dr(SW, 32'h0, d);
    s = d[SW-1:0];
  endtask

  task automatic prep_mem(input logic f1, input logic [AW-1:0] a1,
                          input logic f0, input logic [AW-1:0] a0);
    sa1_on = f1; sa1_a = a1; sa0_on = f0; sa0_a = a0;
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 ce_n", mem_ce_n, 1);
    chk("R9 we_n", mem_we_n, 1);
    chk("R9 oe_n", mem_oe_n, 1);
    chk("R9 dout_en", mem_dout_en, 0);
    chk("R9 tdo", tdo, 0);
  endtask

  task automatic t_bypass();
    logic [3:0] cap;
    logic [31:0] d;
    tap_reset();
    shift_dr(8, 32'hA5, d);
    chk("R8 reset-value bypass", d[7:0], 8'h4A);
    shift_ir(4'h3, cap);
    chk("R8 ir capture", cap, 4'b0001);
    shift_dr(8, 32'h3C, d);
    chk("R8 unknown code bypass", d[7:0], 8'h78);
  endtask

  task automatic t_pass_run();
    logic [3:0] cap;
    logic [SW-1:0] s;
    int w0, r0, v0, nz;
    prep_mem(1'b0, '0, 1'b0, '0);
    w0 = mon_wr; r0 = mon_rd; v0 = mon_viol;
    shift_ir(4'h5, cap);
    read_status(s);
    chk("R1 busy while running", s[SW-1], 1);
    chk("R1 done clear while running", s[SW-2], 0);
    repeat (1300) @(negedge clk);
    read_status(s);
    chk("R4 busy after pass", s[SW-1], 0);
    chk("R4 done after pass", s[SW-2], 1);
    chk("R4 fail after pass", s[SW-3], 0);
    chk("R2 write windows", mon_wr - w0, 5 * NW);
    chk("R2 read windows", mon_rd - r0, 5 * NW);
    nz = 0;
    for (int i = 0; i < NW; i++) if (sram[i] != 4'h0) nz++;
    chk("R2 memory left at zero", nz, 0);
    chk("R3 pin timing violations", mon_viol - v0, 0);
  endtask

  task automatic t_restart_ignored();
    logic [3:0] cap;
    logic [31:0] d;
    logic [SW-1:0] s;
    int w0;
    prep_mem(1'b0, '0, 1'b0, '0);
    w0 = mon_wr;
    shift_ir(4'h5, cap);
    repeat (100) @(negedge clk);
    shift_dr(1, 32'h0, d);
    repeat (1300) @(negedge clk);
    chk("R6 no restart (write count)", mon_wr - w0, 5 * NW);
    read_status(s);
    chk("R6 done", s[SW-2], 1);
  endtask

  task automatic t_faults();
    logic [3:0] cap;
    logic [SW-1:0] s;
    prep_mem(1'b1, 5'd7, 1'b1, 5'd20);
    shift_ir(4'h5, cap);
    repeat (1300) @(negedge clk);
    read_status(s);
    chk("R5 done after faults", s[SW-2], 1);
    chk("R5 fail sticky", s[SW-3], 1);
    chk("R5 element", s[15:13], 1);
    chk("R5 address", s[12:8], 7);
    chk("R5 expected", s[7:4], 4'h0);
    chk("R5 actual", s[3:0], 4'h1);
    prep_mem(1'b0, '0, 1'b1, 5'd20);
    shift_ir(4'h5, cap);
    repeat (1300) @(negedge clk);
    read_status(s);
    chk("R5 element (ones read)", s[15:13], 2);
    chk("R5 address (ones read)", s[12:8], 20);
    chk("R5 expected/actual (ones read)", s[7:0], 8'hF7);
  endtask

  task automatic t_abort();
    logic [3:0] cap;
    logic [SW-1:0] s;
    logic o;
    int w0, r0;
    prep_mem(1'b0, '0, 1'b0, '0);
    shift_ir(4'h5, cap);
    repeat (300) @(negedge clk);
    for (int i = 0; i < 5; i++) tck_cyc(1'b1, 1'b0, o);
    repeat (4) @(negedge clk);
    chk("R7 controls inactive", {mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}, 4'b1110);
    w0 = mon_wr; r0 = mon_rd;
    repeat (200) @(negedge clk);
    chk("R7 no further accesses", (mon_wr - w0) + (mon_rd - r0), 0);
    tck_cyc(1'b0, 1'b0, o);
    read_status(s);
    chk("R7 status cleared", s, 0);
  endtask

  initial begin
    rst_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
    fill_req = 1'b0; sa1_on = 1'b0; sa0_on = 1'b0; sa1_a = '0; sa0_a = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bypass();
    t_pass_run();
    t_restart_ignored();
    t_faults();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule